// File: doc/BRIEF.md
# Interruption Priority Arbiter

This block decides, once per cycle, which of 29 numbered interruption and trap sources a processor core should take next. Each source raises a request bit. The bit is qualified by the status-word bit that governs that source. Among the qualified sources, the block picks one by a fixed group hierarchy. It reports the choice as a registered one-cycle take strobe together with the vector number.

Asynchronous sources are latched into a pending register. These are the high-priority machine check, power fail, external, low-priority machine check and performance monitor. While they are masked they stay there until they are taken and acknowledged. Synchronous traps exist only in the cycle their request is present. If their enable is off, or if the arbiter is busy in that cycle, they are lost.

After each take, the arbiter waits for the surrounding core to return an acknowledge that carries a vector number. The acknowledge clears the matching pending bit and lets the arbiter select again.

Top module: `intr_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `takeOut` is 0 and `vecOut` is 0.
- R2: Candidates rank by group first and by lower vector number within a group. The groups are: group 1 = {1}; group 2 = {2,3,4,5,29}; group 4 = {23,24,25}; group 3 = every other vector from 6 to 28. For example, requests 6, 23 and 29 together yield vector 29.
- R3: A qualified request sampled at a clock edge while the arbiter is idle sets `takeOut` to 1 for exactly the following cycle, with `vecOut` holding the winner. `vecOut` keeps its value until the next take.
- R4: After a take, no further take occurs until a cycle with `ackValid`=1. Once that acknowledge is sampled, a new take can happen at the next edge.
- R5: Asynchronous requests are held pending while masked and are taken once unmasked. The masks are: vector 1 while `pswM`=1; vectors 2, 4 and 5 while `pswI`=0; vector 29 while `pswF`=0.
- R6: A pending bit clears only when `ackValid`=1 and `ackVec` equals its vector number. An acknowledge carrying another number releases the arbiter but leaves the bit pending, so that vector is taken again.
- R7: Synchronous requests are never stored. A request that is removed before it wins is not taken later.
- R8: Vector 3 is requested by `reqIn[3]` or `recCntLsb`, and only while `pswR`=1.
- R9: Vector 19 is suppressed while `pswX`=1. Vectors 23, 24 and 25 require `pswH`, `pswL` and `pswT` respectively to be 1.
- R10: Vector 8 is also requested by `gateBranch` while `pswB`=1. Vector 10 is also requested by `privInstr` while `privLvl` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 29 | Request bits, bit v = vector v |
| recCntLsb | input | 1 | Least significant bit of the recovery counter |
| gateBranch | input | 1 | A gateway branch is executing |
| privInstr | input | 1 | A privileged instruction is executing |
| privLvl | input | PRIV_W | Current privilege level, 0 most privileged |
| pswM | input | 1 | Machine-check mask |
| pswI | input | 1 | External/asynchronous enable |
| pswF | input | 1 | Performance monitor enable |
| pswR | input | 1 | Recovery counter enable |
| pswX | input | 1 | Data break disable |
| pswT | input | 1 | Taken-branch trap enable |
| pswH | input | 1 | Higher-privilege transfer trap enable |
| pswL | input | 1 | Lower-privilege transfer trap enable |
| pswB | input | 1 | Gateway-branch trap condition |
| ackValid | input | 1 | Acknowledge of the taken vector |
| ackVec | input | 5 | Vector number being acknowledged |
| takeOut | output | 1 | One-cycle take strobe |
| vecOut | output | 5 | Vector number of the last take |

## Verification
The bench uses the default PRIV_W of 2, so privilege levels 1 to 3 all act as nonzero levels for vector 10. The vector set is fixed at 29. Random cycles mix sparse request bits and random status words with acknowledges that sometimes name the wrong vector. This lets groups 2 to 4 compete with one another and lets masked asynchronous bits collect while the arbiter waits. Directed sequences cover the cases that random stimulus reaches only rarely: a lost synchronous trap, a wrong-vector acknowledge, and each individual gate bit.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;
  localparam int NUM_VEC = 29;
  localparam int VEC_W   = $clog2(NUM_VEC + 1);
  localparam int NUM_GRP = 4;

  typedef logic [VEC_W-1:0] vec_t;

  typedef struct packed {
    logic capture;
    logic clearPend;
  } arbStrobe_t;

  typedef struct packed {
    logic m;
    logic i;
    logic f;
    logic r;
    logic x;
    logic t;
    logic h;
    logic l;
    logic b;
  } psw_t;

  function automatic int groupOf(input int v);
    if (v == 1) return 1;
    if ((v >= 2 && v <= 5) || v == 29) return 2;
    if (v >= 23 && v <= 25) return 4;
    return 3;
  endfunction

  function automatic logic isAsync(input int v);
    return (v == 1) || (v == 2) || (v == 4) || (v == 5) || (v == 29);
  endfunction
endpackage

// File: rtl/intr_arb_datapath.sv
module intr_arb_datapath
  import intr_arb_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_VEC:1]  reqIn,
  input  logic              recCntLsb,
  input  logic              gateBranch,
  input  logic              privInstr,
  input  logic [PRIV_W-1:0] privLvl,
  input  psw_t              psw,
  input  vec_t              ackVec,
  input  arbStrobe_t        strobe,
  output logic              anyElig,
  output logic              takeOut,
  output vec_t              vecOut
);

  logic [NUM_VEC:1] rawReq;
  logic [NUM_VEC:1] gateOn;
  logic [NUM_VEC:1] cand;
  logic [NUM_VEC:1] elig;
  vec_t             winner;
  logic             takeQ;
  vec_t             vecQ;

  function automatic logic enableOf(input int v, input psw_t p);
    case (v)
      1:         return ~p.m;
      2, 4, 5:   return p.i;
      3:         return p.r;
      19:        return ~p.x;
      23:        return p.h;
      24:        return p.l;
      25:        return p.t;
      29:        return p.f;
      default:   return 1'b1;
    endcase
  endfunction

  // Sources that have side causes besides their own request bit
  always_comb begin
    rawReq     = reqIn;
    rawReq[3]  = reqIn[3] | recCntLsb;
    rawReq[8]  = reqIn[8] | (gateBranch & psw.b);
    rawReq[10] = reqIn[10] | (privInstr & (privLvl != '0));
  end

  for (genvar v = 1; v <= NUM_VEC; v++) begin : g_src
    assign gateOn[v] = enableOf(v, psw);
    if (isAsync(v)) begin : g_async
      logic pendQ;
      always_ff @(posedge clk) begin
        if (!rstN) pendQ <= 1'b0;
        else pendQ <= rawReq[v] |
                      (pendQ & ~(strobe.clearPend && (ackVec == vec_t'(v))));
      end
      assign cand[v] = pendQ | rawReq[v];
    end else begin : g_sync
      assign cand[v] = rawReq[v];
    end
    assign elig[v] = cand[v] & gateOn[v];
  end

  // Group first, then lowest number inside the group
  always_comb begin
    logic found;
    found  = 1'b0;
    winner = '0;
    for (int g = 1; g <= NUM_GRP; g++) begin
      for (int v = 1; v <= NUM_VEC; v++) begin
        if (!found && groupOf(v) == g && elig[v]) begin
          found  = 1'b1;
          winner = vec_t'(v);
        end
      end
    end
  end

  assign anyElig = |elig;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeQ <= 1'b0;
      vecQ  <= '0;
    end else begin
      takeQ <= strobe.capture;
      if (strobe.capture) vecQ <= winner;
    end
  end

  assign takeOut = takeQ;
  assign vecOut  = vecQ;
endmodule

// File: rtl/intr_arb_control.sv
module intr_arb_control
  import intr_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyElig,
  input  logic       ackValid,
  output arbStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_WAIT} arbState_t;
  arbState_t stateQ, stateD;

  always_comb begin
    strobe.capture   = (stateQ == ST_IDLE) && anyElig;
    strobe.clearPend = ackValid;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (anyElig) stateD = ST_WAIT;
      ST_WAIT: if (ackValid) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else stateQ <= stateD;
  end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_arb_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_VEC:1]  reqIn,
  input  logic              recCntLsb,
  input  logic              gateBranch,
  input  logic              privInstr,
  input  logic [PRIV_W-1:0] privLvl,
  input  logic              pswM,
  input  logic              pswI,
  input  logic              pswF,
  input  logic              pswR,
  input  logic              pswX,
  input  logic              pswT,
  input  logic              pswH,
  input  logic              pswL,
  input  logic              pswB,
  input  logic              ackValid,
  input  logic [VEC_W-1:0]  ackVec,
  output logic              takeOut,
  output logic [VEC_W-1:0]  vecOut
);

  psw_t       psw;
  arbStrobe_t strobe;
  logic       anyElig;

  assign psw = '{m: pswM, i: pswI, f: pswF, r: pswR, x: pswX,
                 t: pswT, h: pswH, l: pswL, b: pswB};

  intr_arb_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .anyElig  (anyElig),
    .ackValid (ackValid),
    .strobe   (strobe)
  );

  intr_arb_datapath #(.PRIV_W(PRIV_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqIn      (reqIn),
    .recCntLsb  (recCntLsb),
    .gateBranch (gateBranch),
    .privInstr  (privInstr),
    .privLvl    (privLvl),
    .psw        (psw),
    .ackVec     (ackVec),
    .strobe     (strobe),
    .anyElig    (anyElig),
    .takeOut    (takeOut),
    .vecOut     (vecOut)
  );
endmodule

// File: rtl/intr_arbiter_chk.sv
module intr_arbiter_chk
  import intr_arb_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       pswM,
  input logic       pswF,
  input logic       pswX,
  input logic       pswH,
  input logic       ackValid,
  input logic       takeOut,
  input vec_t       vecOut
);

  logic outstanding;
  always_ff @(posedge clk) begin
    if (!rstN) outstanding <= 1'b0;
    else outstanding <= (outstanding | takeOut) & ~ackValid;
  end

  p_vec_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    takeOut |-> (vecOut != '0 && vecOut <= vec_t'(NUM_VEC)));

  p_take_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    takeOut |=> !takeOut);

  p_vec_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !takeOut |-> $stable(vecOut));

  p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rstN)
    takeOut |-> !outstanding);

  p_m_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    (takeOut && vecOut == vec_t'(1)) |-> $past(!pswM));

  p_f_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    (takeOut && vecOut == vec_t'(29)) |-> $past(pswF));

  p_x_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (takeOut && vecOut == vec_t'(19)) |-> $past(!pswX));

  p_h_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (takeOut && vecOut == vec_t'(23)) |-> $past(pswH));
endmodule

bind intr_arbiter intr_arbiter_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pswM     (pswM),
  .pswF     (pswF),
  .pswX     (pswX),
  .pswH     (pswH),
  .ackValid (ackValid),
  .takeOut  (takeOut),
  .vecOut   (vecOut)
);

// File: tb/intr_arbiter_bench.sv
module intr_arbiter_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [29:1] reqIn;
  logic        recCntLsb, gateBranch, privInstr;
  logic [1:0]  privLvl;
  logic        pswM, pswI, pswF, pswR, pswX, pswT, pswH, pswL, pswB;
  logic        ackValid;
  logic [4:0]  ackVec;
  logic        takeOut;
  logic [4:0]  vecOut;

  int checks = 0;
  int fails  = 0;

  logic [29:1] mPend;
  logic        mWait;
  int          mVec;

  always #10 clk = ~clk;

  intr_arbiter u_intr_arbiter (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .recCntLsb(recCntLsb),
    .gateBranch(gateBranch), .privInstr(privInstr), .privLvl(privLvl),
    .pswM(pswM), .pswI(pswI), .pswF(pswF), .pswR(pswR), .pswX(pswX),
    .pswT(pswT), .pswH(pswH), .pswL(pswL), .pswB(pswB),
    .ackValid(ackValid), .ackVec(ackVec), .takeOut(takeOut), .vecOut(vecOut)
  );

  function automatic int grpOf(int v);
    if (v == 1) return 1;
    if (v == 2 || v == 3 || v == 4 || v == 5 || v == 29) return 2;
    if (v == 23 || v == 24 || v == 25) return 4;
    return 3;
  endfunction

  function automatic bit heldSrc(int v);
    return v == 1 || v == 2 || v == 4 || v == 5 || v == 29;
  endfunction

  function automatic bit gateFor(int v);
    case (v)
      1: return !pswM;
      2, 4, 5: return pswI;
      3: return pswR;
      19: return !pswX;
      23: return pswH;
      24: return pswL;
      25: return pswT;
      29: return pswF;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int pickWinner(logic [29:1] e);
    int best = 0;
    int bestKey = 1000;
    for (int v = 1; v <= 29; v++)
      if (e[v] && (grpOf(v) * 100 + v) < bestKey) begin
        bestKey = grpOf(v) * 100 + v;
        best = v;
      end
    return best;
  endfunction

  task automatic check(string tag, logic gotT, logic expT, int gotV, int expV);
    checks++;
    if (gotT !== expT || gotV != expV) begin
      fails++;
      $display("FAIL %s: take=%0b vec=%0d expected take=%0b vec=%0d",
               tag, gotT, gotV, expT, expV);
    end
  endtask

  // Called at a negedge with inputs applied; advances one clock and checks
  task automatic cycle(string tag);
    logic [29:1] raw, el;
    int w;
    logic expT;
    raw = reqIn;
    raw[3]  = reqIn[3] | recCntLsb;
    raw[8]  = reqIn[8] | (gateBranch & pswB);
    raw[10] = reqIn[10] | (privInstr && privLvl != 0);
    for (int v = 1; v <= 29; v++)
      el[v] = (heldSrc(v) ? (raw[v] | mPend[v]) : raw[v]) & gateFor(v);
    w = pickWinner(el);
    expT = !mWait && (w != 0);
    if (expT) mVec = w;
    for (int v = 1; v <= 29; v++)
      if (heldSrc(v))
        mPend[v] = raw[v] | (mPend[v] & !(ackValid && ackVec == 5'(v)));
    mWait = mWait ? !ackValid : expT;
    @(negedge clk);
    check(tag, takeOut, expT, int'(vecOut), mVec);
  endtask

  task automatic quiet();
    reqIn = '0; recCntLsb = 0; gateBranch = 0; privInstr = 0; privLvl = 0;
    ackValid = 0; ackVec = 0;
  endtask

  task automatic allOn();
    pswM = 0; pswI = 1; pswF = 1; pswR = 1; pswX = 0;
    pswT = 1; pswH = 1; pswL = 1; pswB = 1;
  endtask

  task automatic ack(int v, string tag);
    ackValid = 1; ackVec = 5'(v);
    cycle(tag);
    ackValid = 0; ackVec = 0;
  endtask

  task automatic finish();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: take=%0b vec=%0d expected run to end", takeOut, vecOut);
    finish();
  end

  initial begin
    void'($urandom(32'h1a2b3c));
    quiet(); allOn();
    mPend = '0; mWait = 0; mVec = 0;
    rstN = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", takeOut, 1'b0, int'(vecOut), 0);
    rstN = 1;
    cycle("R1 first cycle");
    check("R1 after reset", takeOut, 1'b0, int'(vecOut), 0);

    // R2 ranking: group 2 beats group 3 and group 4
    reqIn[6] = 1; reqIn[23] = 1; reqIn[29] = 1;
    cycle("R2 rank");
    check("R2 group order", takeOut, 1'b1, int'(vecOut), 29);
    quiet();
    ack(29, "R4 ack release");
    check("R3 strobe one cycle", takeOut, 1'b0, int'(vecOut), 29);
    cycle("R7 sync not held");
    check("R7 dropped traps", takeOut, 1'b0, int'(vecOut), 29);

    // R5 masked external held, R6 wrong ack keeps it
    pswI = 0; reqIn[4] = 1;
    cycle("R5 masked");
    quiet();
    cycle("R5 still masked");
    check("R5 held while masked", takeOut, 1'b0, int'(vecOut), 29);
    pswI = 1;
    cycle("R5 unmask");
    check("R5 taken after unmask", takeOut, 1'b1, int'(vecOut), 4);
    ack(5, "R6 wrong ack");
    cycle("R6 retake");
    check("R6 pending kept", takeOut, 1'b1, int'(vecOut), 4);
    ack(4, "R6 right ack");
    cycle("R6 cleared");
    check("R6 cleared", takeOut, 1'b0, int'(vecOut), 4);

    // R9 gates
    pswX = 1; reqIn[19] = 1;
    cycle("R9 X suppress");
    check("R9 X suppress", takeOut, 1'b0, int'(vecOut), 4);
    pswX = 0;
    cycle("R9 X open");
    check("R9 data break", takeOut, 1'b1, int'(vecOut), 19);
    quiet(); ack(19, "R9 ack");
    pswL = 0; reqIn[24] = 1;
    cycle("R9 L gate");
    check("R9 L gate", takeOut, 1'b0, int'(vecOut), 19);
    quiet(); allOn();

    // R8 recovery counter
    pswR = 0; recCntLsb = 1;
    cycle("R8 R off");
    check("R8 R off", takeOut, 1'b0, int'(vecOut), 19);
    pswR = 1;
    cycle("R8 R on");
    check("R8 recovery", takeOut, 1'b1, int'(vecOut), 3);
    quiet(); ack(3, "R8 ack");

    // R10 privileged and gateway
    privInstr = 1; privLvl = 0;
    cycle("R10 level 0");
    check("R10 level 0", takeOut, 1'b0, int'(vecOut), 3);
    privLvl = 2;
    cycle("R10 level 2");
    check("R10 privileged", takeOut, 1'b1, int'(vecOut), 10);
    quiet(); ack(10, "R10 ack");
    gateBranch = 1;
    cycle("R10 gateway");
    check("R10 gateway", takeOut, 1'b1, int'(vecOut), 8);
    quiet(); ack(8, "R10 ack8");

    // R4 no second take until ack; R5 vector 1 under M
    reqIn[1] = 1; reqIn[2] = 1;
    cycle("R4 take");
    check("R4 first take", takeOut, 1'b1, int'(vecOut), 1);
    quiet();
    repeat (3) cycle("R4 wait");
    check("R4 no take while waiting", takeOut, 1'b0, int'(vecOut), 1);
    ack(1, "R4 ack");
    cycle("R4 next");
    check("R4 next pending", takeOut, 1'b1, int'(vecOut), 2);
    ack(2, "R4 ack2");
    cycle("R4 idle");

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      for (int v = 1; v <= 29; v++) reqIn[v] = ($urandom_range(0, 24) == 0);
      recCntLsb  = ($urandom_range(0, 9) == 0);
      gateBranch = ($urandom_range(0, 9) == 0);
      privInstr  = ($urandom_range(0, 9) == 0);
      privLvl    = 2'($urandom_range(0, 3));
      {pswM, pswI, pswF, pswR, pswX, pswT, pswH, pswL, pswB} = 9'($urandom);
      ackValid = ($urandom_range(0, 2) == 0);
      ackVec   = ($urandom_range(0, 9) < 7) ? 5'(mVec) : 5'($urandom_range(0, 29));
      cycle("R2 R3 R5 random");
    end
    quiet(); allOn();
    cycle("R2 R3 R5 random end");
    finish();
  end
endmodule